// File: doc/BRIEF.md
# Register-Window DMA Burst Sequencer

The sequencer sits between a peripheral's register file and one fixed 32-bit data window that a DMA engine reads or writes. The DMA only ever touches the window address. The sequencer redirects each window access to a real register in the file. The first access of a burst lands on a programmed start index. Each later access lands one 32-bit register higher. After a programmed number of accesses, the pointer returns to the start index, ready for the next burst.

A configuration word next to the window holds the two 5-bit fields: the start index and the burst length. Software writes it once before the DMA is armed. Writing it again restarts the burst from the start index. Bus accesses are decoded combinationally and forwarded to the register file in the same cycle. The pointer moves on the clock edge that completes a window access.

Top module: `regwin_burst_seq`

## Requirements
- R1: After reset, the configuration word reads as 0, and the first window access goes to the register-file base address.
- R2: A word read of the configuration word (byte offset 0x48) returns the start index in bits [4:0] and the length field in bits [12:8]. All other bits read 0, whatever value was written to them.
- R3: The first window access (byte offset 0x4C) after a configuration write goes to byte address base + start*4.
- R4: Each later window access in a burst goes to the register 4 bytes above the previous one.
- R5: A length field of N gives N+1 window accesses per burst. The access after the last one goes back to base + start*4.
- R6: A configuration write in the middle of a burst makes the next window access go to the newly written start index.
- R7: An access whose byte enables are not all four set (4'hF) is ignored. It raises no register-file strobe, does not move the pointer, does not change the configuration, and returns read data 0.
- R8: The register index is (start + position) modulo 32, so a burst that runs past index 31 continues at index 0.
- R9: A window write raises rf_we_o and forwards the bus write data. A window read returns rf_rdata_i on bus_rdata_o. Both happen in the same cycle as the bus access.
- R10: An access to any other offset raises no strobe, returns 0 and leaves the pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| rf_req_o | output | 1 | Register-file access strobe |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 12 | Register-file byte address |
| rf_wdata_o | output | 32 | Data written to the register file |
| rf_rdata_i | input | 32 | Data read from the register file |

## Verification
The hardest case to reach is a burst that crosses index 31 while it is also interrupted. That means the modulo-32 wrap has to occur in the middle of a burst, next to a mid-burst reprogram or an ignored partial-width access. Directed sequences set a start index of 30 with a length long enough to wrap. Randomly mixed configuration writes, partial byte-enable accesses and stray offsets then keep hitting the pointer at arbitrary positions. A bench model tracks the expected position and predicts every target address.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned LEN_LSB = 8;
  localparam logic [BE_W-1:0] FULL_BE = '1;

  typedef struct packed {
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] start;
  } win_cfg_t;
endpackage

// File: rtl/regwin_cfg.sv
module regwin_cfg
  import regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output win_cfg_t          cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  win_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_i) begin
      cfg_q.start <= wdata_i[IDX_W-1:0];
      cfg_q.len   <= wdata_i[LEN_LSB +: IDX_W];
    end
  end

  // reserved bits are not stored
  always_comb begin
    rdata_o = '0;
    rdata_o[IDX_W-1:0]        = cfg_q.start;
    rdata_o[LEN_LSB +: IDX_W] = cfg_q.len;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
  import regwin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  win_cfg_t         cfg_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] pos_o,
  output logic             last_o
);
  logic [IDX_W-1:0] pos_q;

  assign last_o = (pos_q == cfg_i.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (step_i) pos_q <= last_o ? '0 : pos_q + 1'b1;
  end

  // natural truncation gives modulo-32 wrap
  assign idx_o = cfg_i.start + pos_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/regwin_burst_seq.sv
module regwin_burst_seq
  import regwin_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned RF_AW  = 12,
  parameter logic [BUS_AW-1:0] CFG_OFS = 8'h48,
  parameter logic [BUS_AW-1:0] WIN_OFS = 8'h4C,
  parameter logic [RF_AW-1:0]  RF_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rf_req_o,
  output logic              rf_we_o,
  output logic [RF_AW-1:0]  rf_addr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);
  localparam int unsigned OFS_W = IDX_W + 2;

  logic              word_acc, hit_cfg, hit_win, cfg_wr, cfg_rd;
  logic [DATA_W-1:0] cfg_rdata;
  logic [IDX_W-1:0]  idx, pos;
  logic              last;
  win_cfg_t          cfg;

  assign word_acc = bus_req_i && (bus_be_i == FULL_BE);
  assign hit_cfg  = word_acc && (bus_addr_i == CFG_OFS);
  assign hit_win  = word_acc && (bus_addr_i == WIN_OFS);
  assign cfg_wr   = hit_cfg && bus_we_i;
  assign cfg_rd   = hit_cfg && !bus_we_i;

  regwin_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .wdata_i (bus_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata)
  );

  regwin_ptr u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_wr),
    .step_i (hit_win),
    .cfg_i  (cfg),
    .idx_o  (idx),
    .pos_o  (pos),
    .last_o (last)
  );

  assign rf_req_o   = hit_win;
  assign rf_we_o    = hit_win && bus_we_i;
  assign rf_addr_o  = RF_BASE + RF_AW'({idx, 2'b00});
  assign rf_wdata_o = bus_wdata_i;

  always_comb begin
    bus_rdata_o = '0;
    if (cfg_rd)                      bus_rdata_o = cfg_rdata;
    else if (hit_win && !bus_we_i)   bus_rdata_o = rf_rdata_i;
  end

  logic unused_ofs;
  assign unused_ofs = ^{OFS_W[0], last};
endmodule

// File: rtl/regwin_burst_seq_chk.sv
module regwin_burst_seq_chk
  import regwin_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic [BE_W-1:0]   bus_be_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              rf_req_o,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [IDX_W-1:0]  pos,
  input win_cfg_t          cfg
);
  a_r7_partial_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_be_i != FULL_BE) |-> !rf_req_o);

  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && pos != cfg.len) |=> pos == $past(pos) + 1'b1);

  a_r5_burst_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && pos == cfg.len) |=> pos == '0);

  a_r6_cfg_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> pos == '0);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rf_req_o && !cfg_wr) |=> $stable(pos) && $stable(cfg));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd |-> (bus_rdata_o[DATA_W-1:LEN_LSB+IDX_W] == '0 &&
                bus_rdata_o[LEN_LSB-1:IDX_W] == '0));
endmodule

bind regwin_burst_seq regwin_burst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_be_i    (bus_be_i),
  .bus_rdata_o (bus_rdata_o),
  .rf_req_o    (rf_req_o),
  .cfg_wr      (cfg_wr),
  .cfg_rd      (cfg_rd),
  .pos         (pos),
  .cfg         (cfg)
);

// File: tb/regwin_burst_seq_test.sv
`timescale 1ns/1ps
module regwin_burst_seq_test;
  localparam logic [7:0] CFG_A = 8'h48;
  localparam logic [7:0] WIN_A = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rf_req, rf_we;
  logic [11:0] rf_addr;
  logic [31:0] rf_wdata, rf_rdata;

  int unsigned nvec = 0, nerr = 0;
  logic [4:0] m_start = '0, m_len = '0, m_pos = '0;

  always #2.5 clk = ~clk;

  assign rf_rdata = 32'h5A00_0000 | {20'h0, rf_addr};

  regwin_burst_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
    .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
  );

  function automatic logic [11:0] exp_addr(logic [4:0] s, logic [4:0] p);
    logic [4:0] i;
    i = s + p;
    return {5'h0, i, 2'b00};
  endfunction

  function automatic logic [31:0] exp_cfg(logic [4:0] s, logic [4:0] l);
    return {19'h0, l, 3'h0, s};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d, input string tag);
    bit word, win, cf;
    word = (b == 4'hF);
    win  = word && a == WIN_A;
    cf   = word && a == CFG_A;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    #1;
    chk(rf_req == win, tag, {31'h0, rf_req}, {31'h0, win});
    if (win) begin
      chk(rf_addr == exp_addr(m_start, m_pos), tag, {20'h0, rf_addr}, {20'h0, exp_addr(m_start, m_pos)});
      chk(rf_we == w, {tag, "/R9"}, {31'h0, rf_we}, {31'h0, w});
      if (w) chk(rf_wdata == d, {tag, "/R9"}, rf_wdata, d);
      else   chk(rdata == (32'h5A00_0000 | {20'h0, exp_addr(m_start, m_pos)}), {tag, "/R9"},
                 rdata, 32'h5A00_0000 | {20'h0, exp_addr(m_start, m_pos)});
    end else if (cf && !w) begin
      chk(rdata == exp_cfg(m_start, m_len), {tag, "/R2"}, rdata, exp_cfg(m_start, m_len));
    end else if (!cf) begin
      chk(rdata == 32'h0, {tag, "/R7/R10"}, rdata, 32'h0);
    end
    @(posedge clk);
    if (cf && w) begin
      m_start = d[4:0]; m_len = d[12:8]; m_pos = '0;
    end else if (win) begin
      m_pos = (m_pos == m_len) ? 5'd0 : m_pos + 5'd1;
    end
    #1;
    req = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    access(1'b0, CFG_A, 4'hF, 0, "R1");
    access(1'b0, WIN_A, 4'hF, 0, "R1");
    access(1'b0, WIN_A, 4'hF, 0, "R1");

    // R2 reserved bits drop
    access(1'b1, CFG_A, 4'hF, 32'hFFFF_FFFF, "R2");
    access(1'b0, CFG_A, 4'hF, 0, "R2");

    // R3 R4 R5 start 3, length field 2
    access(1'b1, CFG_A, 4'hF, 32'h0000_0203, "R3");
    access(1'b0, WIN_A, 4'hF, 0, "R3");
    access(1'b1, WIN_A, 4'hF, 32'hDEAD_BEEF, "R4");
    access(1'b0, WIN_A, 4'hF, 0, "R4");
    access(1'b0, WIN_A, 4'hF, 0, "R5");

    // R6 restart mid-burst
    access(1'b0, WIN_A, 4'hF, 0, "R6");
    access(1'b1, CFG_A, 4'hF, 32'h0000_0507, "R6");
    access(1'b0, WIN_A, 4'hF, 0, "R6");

    // R7 partial accesses ignored
    access(1'b1, WIN_A, 4'h3, 32'h1111_2222, "R7");
    access(1'b0, WIN_A, 4'h1, 0, "R7");
    access(1'b1, CFG_A, 4'h7, 32'h0000_1F1F, "R7");
    access(1'b0, CFG_A, 4'hF, 0, "R7");
    access(1'b0, WIN_A, 4'hF, 0, "R7");

    // R8 wrap past index 31
    access(1'b1, CFG_A, 4'hF, 32'h0000_041E, "R8");
    for (int i = 0; i < 6; i++) access(1'b0, WIN_A, 4'hF, 0, "R8");

    // R10 stray offsets
    access(1'b1, 8'h44, 4'hF, 32'h0000_0000, "R10");
    access(1'b0, 8'h50, 4'hF, 0, "R10");
    access(1'b0, WIN_A, 4'hF, 0, "R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      logic [7:0] a;
      logic [3:0] b;
      k = $urandom_range(0, 99);
      a = (k < 70) ? WIN_A : (k < 80) ? CFG_A : 8'($urandom_range(0, 31) * 4);
      b = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      access(1'($urandom_range(0, 1)), a, b, $urandom, "R4-rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule